// File: doc/BRIEF.md
# Serial GPIO Shift Engine

The block carries up to 80 general-purpose I/O slots over a four-wire serial link: a serial clock, a load strobe, a data-out line and a data-in line. External shift-register chains sit on the far side of the link. One control word turns the link on and sets how many slots each frame carries, in groups of eight. It also sets a clock divider that fixes the serial bit rate as a fraction of the system clock.

Every slot is both an input and an output. Software writes output levels into an output latch and reads sampled input levels from a value register, both arranged as 32-bit banks. Each frame starts with a load period of one serial clock. The engine then shifts the latched outputs out, highest active slot first, and shifts the same number of input bits in. When the last bit of a frame has been sampled, the captured inputs are moved into the value register in one step.

Top module: `sgpio_engine`

## Requirements
- R1: After reset the serial clock is high, the load strobe and data-out are low, and every register address reads zero.
- R2: The control word at address 0 holds enable at bit 0, the slot-group count at bits 9:6 and the divider at bits 31:16. All other bits read zero. A group count above 10 is stored and read back as 10.
- R3: While enable is low, the serial clock stays high and the load strobe and data-out stay low.
- R4: While enabled, the serial clock alternates high and low phases of div+1 system clocks each, starting high. Its first falling edge comes div+1 clocks after enable takes effect.
- R5: Each frame is one serial period with the load strobe high, lasting 2*(div+1) system clocks, followed by N = 8*groups bit periods with the strobe low.
- R6: In bit period k (k = 1..N), data-out carries output-latch slot N-k. It changes only right after a falling serial clock edge.
- R7: The data-in level at the rising serial clock edge that ends bit period k is captured for slot N-k.
- R8: The value register changes only when a frame ends, and then takes the whole frame's captured inputs at once. A read during a frame returns the previous frame.
- R9: Slot n lives in bank n>>5, bit n&31. Address 1+b reads value bank b and writes output-latch bank b. Address 4+b reads output-latch bank b.
- R10: Bits of slots at or above N, and of slots 80 and up, read zero in both value and latch banks.
- R11: Writes to the latch read-back addresses 4 to 6 leave the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| sclk_o | output | 1 | Serial clock, idles high |
| sload_o | output | 1 | Frame load strobe, active high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
Assertions check on every cycle that the serial clock holds high while disabled and toggles only when its half-period count runs out. They also check that data-out holds steady between falling edges, that the value register moves only at a frame end, that the group count never exceeds ten, and that writes to read-back addresses leave the latch alone. Only the bench scenarios can show the slot order on the wire and the bit taken from data-in for each slot. They also show the exact phase widths for several dividers, the frame length for several group counts, and that a read in the middle of a frame returns the older frame.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PINS_LSB = 6;
  localparam int unsigned PINS_W   = 4;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned DIV_W    = 16;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [PINS_W-1:0] groups;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/sgp_regs.sv
module sgp_regs
  import sgp_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 80,
  parameter int unsigned NBANK     = 3,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SLOT_W    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output ctrl_t                ctrl_o,
  output logic [SLOT_W-1:0]    n_slots_o,
  output logic [MAX_SLOTS-1:0] latch_o,
  input  logic [MAX_SLOTS-1:0] value_i
);
  localparam int unsigned MAX_GROUPS = MAX_SLOTS / 8;
  localparam int unsigned VAL_BASE   = 1;
  localparam int unsigned RB_BASE    = 1 + NBANK;
  localparam int unsigned PAD_W      = NBANK * REG_W;

  ctrl_t                ctrl_q;
  logic [MAX_SLOTS-1:0] latch_q;
  logic [PINS_W-1:0]    wgroups;
  logic [PAD_W-1:0]     msk_pad, val_pad, lat_pad;

  assign wgroups   = wdata_i[PINS_LSB +: PINS_W];
  assign n_slots_o = SLOT_W'({ctrl_q.groups, 3'b000});
  assign ctrl_o    = ctrl_q;
  assign latch_o   = latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      latch_q <= '0;
    end else if (we_i) begin
      if (addr_i == '0) begin
        ctrl_q.en     <= wdata_i[EN_BIT];
        ctrl_q.div    <= wdata_i[DIV_LSB +: DIV_W];
        ctrl_q.groups <= (wgroups > PINS_W'(MAX_GROUPS)) ? PINS_W'(MAX_GROUPS) : wgroups;
      end
      for (int i = 0; i < MAX_SLOTS; i++) begin
        if (addr_i == ADDR_W'(VAL_BASE + i / REG_W)) latch_q[i] <= wdata_i[i % REG_W];
      end
    end
  end

  // bank-padded views; slots beyond the frame or the array read zero
  for (genvar i = 0; i < PAD_W; i++) begin : g_pad
    if (i < MAX_SLOTS) begin : g_live
      assign msk_pad[i] = (32'(n_slots_o) > i);
      assign val_pad[i] = value_i[i];
      assign lat_pad[i] = latch_q[i];
    end else begin : g_dead
      assign msk_pad[i] = 1'b0;
      assign val_pad[i] = 1'b0;
      assign lat_pad[i] = 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[EN_BIT]                = ctrl_q.en;
      rdata_o[PINS_LSB +: PINS_W]    = ctrl_q.groups;
      rdata_o[DIV_LSB +: DIV_W]      = ctrl_q.div;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (addr_i == ADDR_W'(VAL_BASE + b))
        rdata_o = val_pad[b*REG_W +: REG_W] & msk_pad[b*REG_W +: REG_W];
      if (addr_i == ADDR_W'(RB_BASE + b))
        rdata_o = lat_pad[b*REG_W +: REG_W] & msk_pad[b*REG_W +: REG_W];
    end
  end

  p_groups_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.groups <= PINS_W'(MAX_GROUPS));

  p_rb_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(RB_BASE)) |=> $stable(latch_q));
endmodule

// File: rtl/sgp_clkgen.sv
module sgp_clkgen
  import sgp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] hcnt_q;
  logic             sclk_q;
  logic             hit;

  assign hit    = (hcnt_q >= div_i);
  assign fall_o = en_i & hit & sclk_q;
  assign rise_o = en_i & hit & ~sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      hcnt_q <= '0;
      sclk_q <= 1'b1;
    end else if (hit) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sclk_q);

  p_half_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fall_o && !rise_o) |=> $stable(sclk_q));
endmodule

// File: rtl/sgp_frame.sv
module sgp_frame #(
  parameter int unsigned MAX_SLOTS = 80,
  parameter int unsigned SLOT_W    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [SLOT_W-1:0]    n_i,
  input  logic                 fall_i,
  input  logic                 rise_i,
  input  logic                 sdi_i,
  input  logic [MAX_SLOTS-1:0] latch_i,
  output logic [MAX_SLOTS-1:0] value_o,
  output logic                 load_o,
  output logic                 sdo_o
);
  logic [SLOT_W-1:0]    per_q;     // 0 = load period, 1..N = bit periods
  logic [SLOT_W-1:0]    idx;
  logic [MAX_SLOTS-1:0] cap_q, cap_nxt, value_q;
  logic                 sdo_q;
  logic                 in_bits, last;

  assign idx     = n_i - per_q;
  assign in_bits = (per_q != '0) && (idx < SLOT_W'(MAX_SLOTS));
  assign last    = (per_q >= n_i);
  assign load_o  = en_i && (per_q == '0);
  assign sdo_o   = sdo_q;
  assign value_o = value_q;

  always_comb begin
    cap_nxt = cap_q;
    if (rise_i && in_bits) cap_nxt[idx] = sdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      sdo_q   <= 1'b0;
      cap_q   <= '0;
      value_q <= '0;
    end else if (!en_i) begin
      per_q <= '0;
      sdo_q <= 1'b0;
    end else begin
      cap_q <= cap_nxt;
      if (fall_i && in_bits) sdo_q <= latch_i[idx];
      if (rise_i) begin
        per_q <= last ? '0 : per_q + 1'b1;
        if (last) value_q <= cap_nxt;
      end
    end
  end

  p_per_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q <= SLOT_W'(MAX_SLOTS));

  p_sdo_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fall_i) |=> $stable(sdo_q));

  p_value_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && last) |=> $stable(value_q));
endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine
  import sgp_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 80,
  localparam int unsigned NBANK    = (MAX_SLOTS + REG_W - 1) / REG_W,
  localparam int unsigned ADDR_W   = $clog2(2 * NBANK + 1),
  localparam int unsigned SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              sclk_o,
  output logic              sload_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  ctrl_t                ctrl;
  logic [SLOT_W-1:0]    n_slots;
  logic [MAX_SLOTS-1:0] latch, value;
  logic                 fall, rise;

  sgp_regs #(
    .MAX_SLOTS(MAX_SLOTS), .NBANK(NBANK), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ctrl_o    (ctrl),
    .n_slots_o (n_slots),
    .latch_o   (latch),
    .value_i   (value)
  );

  sgp_clkgen u_clkgen (
    .clk_i, .rst_ni,
    .en_i   (ctrl.en),
    .div_i  (ctrl.div),
    .sclk_o (sclk_o),
    .fall_o (fall),
    .rise_o (rise)
  );

  sgp_frame #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_frame (
    .clk_i, .rst_ni,
    .en_i    (ctrl.en),
    .n_i     (n_slots),
    .fall_i  (fall),
    .rise_i  (rise),
    .sdi_i   (sdi_i),
    .latch_i (latch),
    .value_o (value),
    .load_o  (sload_o),
    .sdo_o   (sdo_o)
  );
endmodule

// File: tb/sgpio_engine_tb.sv
module sgpio_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, sload, sdo;
  logic        sdi = 1'b0;

  int n_cmp = 0, n_bad = 0;
  logic [95:0] lat_model = '0, ext_in = '0;
  int cur_n = 0, cur_div = 0;
  bit mon_en = 0, seen_edge = 0, have_frame = 0;
  int run = 0, lcnt = 0, k = 0, frames = 0;
  logic prev_sclk = 1'b1, prev_load = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgpio_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk),
    .sload_o(sload), .sdo_o(sdo), .sdi_i(sdi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_bank(input logic [95:0] v, input int b, input int n);
    logic [31:0] r = '0;
    for (int j = 0; j < 32; j++) begin
      int i = b * 32 + j;
      r[j] = (i < 80 && i < n) ? v[i] : 1'b0;
    end
    return r;
  endfunction

  // external chain model and wire-level checks
  always @(negedge clk) begin
    if (!mon_en) begin
      seen_edge = 0; have_frame = 0; run = 0; lcnt = 0; k = 0;
      prev_sclk = sclk; prev_load = sload;
    end else begin
      if (sclk != prev_sclk) begin
        if (seen_edge) chk("R4 phase width", run, cur_div + 1);
        seen_edge = 1; run = 1;
        if (!sclk && !sload) begin
          k++;
          if (k <= cur_n) begin
            sdi = ext_in[cur_n - k];
            chk("R6 slot order on sdo", {31'b0, sdo}, {31'b0, lat_model[cur_n - k]});
          end
        end
      end else run++;
      if (sload && !prev_load) begin
        if (have_frame) chk("R5 bits per frame", k, cur_n);
        have_frame = 1; k = 0; frames++; lcnt = 1;
      end else if (sload) lcnt++;
      else if (prev_load) chk("R5 load width", lcnt, 2 * (cur_div + 1));
      prev_sclk = sclk; prev_load = sload;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1 addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic set_ctrl(input bit en, input int g, input int dv);
    int n;
    @(posedge clk); #1
    if (!en) mon_en = 0;
    cur_div = dv; cur_n = (g > 10 ? 10 : g) * 8;
    we = 1; addr = 3'd0; wdata = {dv[15:0], 6'b0, g[3:0], 5'b0, en};
    @(posedge clk); #1 we = 0;
    if (en) begin
      mon_en = 1;
      n = 0;
      do begin @(negedge clk); n++; end while (sclk);
      chk("R4 first fall latency", n, dv + 2);
    end
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(posedge clk);
  endtask

  task automatic check_values(input string tag);
    logic [31:0] v;
    for (int b = 0; b < 3; b++) begin
      rd(3'(1 + b), v);
      chk(tag, v, exp_bank(ext_in, b, cur_n));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    logic [95:0] prev_in;
    int divs[6], grps[6], f0;
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 sclk", {31'b0, sclk}, 32'd1);
    chk("R1 load", {31'b0, sload}, 32'd0);
    chk("R1 sdo", {31'b0, sdo}, 32'd0);
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 register", v, 32'd0); end

    // R2 control packing, clamp and unused bits
    wr(3'd0, 32'h1234_F3FE);
    rd(3'd0, v); chk("R2 control readback", v, 32'h1234_0280);
    @(negedge clk);
    chk("R3 idle sclk", {31'b0, sclk}, 32'd1);
    chk("R3 idle load", {31'b0, sload}, 32'd0);

    // R9 R10 R11 latch banks with 24 active slots
    set_ctrl(0, 3, 0);
    for (int b = 0; b < 3; b++) begin
      d = $urandom; wr(3'(1 + b), d); lat_model[b*32 +: 32] = d;
    end
    for (int b = 0; b < 3; b++) begin
      rd(3'(4 + b), v); chk("R10 readback mask 24 slots", v, exp_bank(lat_model, b, 24));
    end
    wr(3'd4, ~lat_model[31:0]);
    set_ctrl(0, 10, 0);
    for (int b = 0; b < 3; b++) begin
      rd(3'(4 + b), v); chk("R11 R9 readback after ignored write", v, exp_bank(lat_model, b, 80));
    end

    // running scenarios
    divs = '{0, 2, 1, 0, 0, 0}; grps = '{1, 3, 10, 0, 0, 15};
    for (int t = 3; t < 5; t++) begin divs[t] = $urandom % 4; grps[t] = 1 + $urandom % 10; end
    divs[5] = 3;
    for (int t = 0; t < 6; t++) begin
      set_ctrl(0, grps[t], divs[t]);
      for (int b = 0; b < 3; b++) begin
        d = $urandom; wr(3'(1 + b), d); lat_model[b*32 +: 32] = d;
      end
      rd(3'd5, v); chk("R9 latch bank 1 readback", v, exp_bank(lat_model, 1, cur_n));
      ext_in = {$urandom, $urandom, $urandom};
      f0 = frames;
      set_ctrl(1, grps[t], divs[t]);
      wait_frames(f0 + 2);
      check_values("R7 captured inputs");
      if (t == 2) begin
        prev_in = ext_in;
        wait_frames(frames + 1);
        ext_in = {$urandom, $urandom, $urandom};
        while (!(k == cur_n / 2 && !sload)) @(posedge clk);
        for (int b = 0; b < 3; b++) begin
          rd(3'(1 + b), v); chk("R8 mid-frame read holds old frame", v, exp_bank(prev_in, b, cur_n));
        end
        wait_frames(frames + 1);
        check_values("R8 whole frame transferred");
      end
      set_ctrl(0, grps[t], divs[t]);
      repeat (3) @(negedge clk);
      chk("R3 disabled sclk", {31'b0, sclk}, 32'd1);
      chk("R3 disabled load", {31'b0, sload}, 32'd0);
      chk("R3 disabled sdo", {31'b0, sdo}, 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule